// File: doc/BRIEF.md
# Packed Bidirectional Saturating Variable Shifter

This block shifts every lane of a 64-bit operand by one signed 8-bit shift amount. A non-negative amount shifts left. When saturation is enabled, a lane that would lose set bits is clamped to its unsigned maximum. A negative amount shifts right logically by its magnitude. Rounding can be enabled, in which case half a unit rounds up. Amounts at or beyond the lane width give defined results.

A two-bit mode input picks how the word is split: four 16-bit lanes, two 32-bit lanes, one 32-bit scalar in the low half, or one 64-bit scalar. The 64-bit scalar never saturates. The result is held in an output register. A one-cycle saturation pulse comes out with each result, and it sets a sticky status bit that only a clear input or reset can lower. An execution unit drives the operands and controls directly from its decode stage.

Top module: `pshift_top`

## Requirements
- R1: The shift amount `shamt_i` is an 8-bit two's-complement value (-128..127). Bit 7 set means a right shift by the magnitude, and 127 and -128 are both legal.
- R2: `mode_i` encodings are 0 = four 16-bit lanes (lane 0 in bits 15:0), 1 = two 32-bit lanes, 2 = 32-bit scalar, 3 = 64-bit scalar. Every lane uses the same amount and is computed independently.
- R3: For a non-negative amount with `sat_en_i`=1, a lane that would lose a set bit becomes all ones; otherwise it is the plain left shift. An amount at or above the lane width saturates any non-zero lane, and a zero lane stays zero.
- R4: For a non-negative amount with `sat_en_i`=0, each lane is the left shift truncated to the lane width. An amount at or above the width gives zero.
- R5: For a negative amount with `round_en_i`=0, each lane is shifted right logically by the magnitude m. When m is at least the lane width the lane is zero.
- R6: For a negative amount with `round_en_i`=1, each lane is ((x >> (m-1)) + 1) >> 1, computed one bit wider than the lane. The lane is zero only when m exceeds the width, and m equal to the width gives the lane's top bit.
- R7: In mode 3 no saturation takes place and `sat_pulse_o` stays 0. A left shift below 64 is a logical shift, and a shift of 64 or more gives zero.
- R8: `sat_sticky_o` is set in the cycle `sat_pulse_o` rises and stays set until `sat_clr_i` or reset. A clear in the same cycle as a saturating operation leaves it set.
- R9: `sat_pulse_o` is 1 only for an operation issued with `valid_i`=1 and `sat_en_i`=1 in which some active lane saturated. While `valid_i`=0, `result_o` holds its value.
- R10: In mode 2 only the low 32-bit lane is used, and `result_o[63:32]` is zero.
- R11: `result_o`, `sat_pulse_o` and `valid_o` appear one clock after `valid_i`. Reset clears `result_o`, `valid_o`, `sat_pulse_o` and `sat_sticky_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation issue strobe |
| mode_i | input | 2 | Lane layout select |
| round_en_i | input | 1 | Round-half-up on right shifts |
| sat_en_i | input | 1 | Saturation on left shifts |
| sat_clr_i | input | 1 | Clears the sticky status bit |
| opa_i | input | 64 | Operand to shift |
| shamt_i | input | 8 | Signed shift amount |
| result_o | output | 64 | Shifted result |
| valid_o | output | 1 | Result valid |
| sat_pulse_o | output | 1 | Saturation occurred in this result |
| sat_sticky_o | output | 1 | Sticky saturation status |

## Verification
The assertions assume that the controls and operands carry known values whenever `valid_i` is high. They also assume `mode_i` is stable across the issue edge. The lane rounding check is skipped while its inputs are unknown.

The stimulus drives every input at the falling edge from a fully defined vector. During idle cycles it keeps `valid_i` low, so the held-result property sees only deliberate issues. Corner amounts of 127, -128 and exactly plus or minus the lane width are driven only as legal 8-bit codes.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  localparam int AMT_W  = 8;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    MODE_H16 = 2'd0,
    MODE_W32 = 2'd1,
    MODE_S32 = 2'd2,
    MODE_D64 = 2'd3
  } pshift_mode_e;
endpackage

// File: rtl/pshift_lane.sv
module pshift_lane #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic [W-1:0]  x_i,
  input  logic [AW-1:0] amt_i,
  input  logic          rnd_i,
  input  logic          sat_i,
  output logic [W-1:0]  y_o,
  output logic          lost_o
);
  logic          neg;
  logic [AW:0]   ext;
  logic [AW:0]   mag;
  logic [2*W-1:0] wide;
  logic [W-1:0]  left_trunc;
  logic          left_lost;
  logic [W-1:0]  right_plain;
  logic [W:0]    rnd_tmp;
  logic [W-1:0]  right_rnd;

  always_comb begin
    neg  = amt_i[AW-1];
    ext  = {amt_i[AW-1], amt_i};
    mag  = neg ? (~ext + 1'b1) : ext;

    if (mag >= W) begin
      wide       = '0;
      left_trunc = '0;
      left_lost  = |x_i;
    end else begin
      wide       = {{W{1'b0}}, x_i} << mag;
      left_trunc = wide[W-1:0];
      left_lost  = |wide[2*W-1:W];
    end

    right_plain = (mag >= W) ? '0 : (x_i >> mag);

    rnd_tmp = ({1'b0, x_i} >> (mag - 1'b1)) + 1'b1;
    if (mag > W) right_rnd = '0;
    else         right_rnd = W'(rnd_tmp >> 1);

    lost_o = !neg && left_lost;
    if (neg)                 y_o = rnd_i ? right_rnd : right_plain;
    else if (sat_i && left_lost) y_o = '1;
    else                     y_o = left_trunc;
  end

  // R6: rounded right shift differs from the plain one by at most one unit
  always_comb begin
    if (!$isunknown({x_i, amt_i}) && neg)
      p_round_step_r6: assert ((right_rnd == right_plain) ||
                               (right_rnd == right_plain + 1'b1));
  end
endmodule

// File: rtl/pshift_core.sv
module pshift_core
  import pshift_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 16,
  parameter int WW = 32,
  parameter int AW = 8
) (
  input  logic [1:0]    mode_i,
  input  logic          rnd_i,
  input  logic          sat_i,
  input  logic [DW-1:0] x_i,
  input  logic [AW-1:0] amt_i,
  output logic [DW-1:0] y_o,
  output logic          sat_o
);
  localparam int NH = DW / HW;
  localparam int NW = DW / WW;

  logic [DW-1:0] h_res, w_res, d_res;
  logic [NH-1:0] h_lost;
  logic [NW-1:0] w_lost;
  logic          d_lost;

  for (genvar i = 0; i < NH; i++) begin : g_half
    pshift_lane #(.W(HW), .AW(AW)) u_lane (
      .x_i(x_i[i*HW +: HW]), .amt_i(amt_i), .rnd_i(rnd_i), .sat_i(sat_i),
      .y_o(h_res[i*HW +: HW]), .lost_o(h_lost[i]));
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    pshift_lane #(.W(WW), .AW(AW)) u_lane (
      .x_i(x_i[i*WW +: WW]), .amt_i(amt_i), .rnd_i(rnd_i), .sat_i(sat_i),
      .y_o(w_res[i*WW +: WW]), .lost_o(w_lost[i]));
  end

  pshift_lane #(.W(DW), .AW(AW)) u_dbl (
    .x_i(x_i), .amt_i(amt_i), .rnd_i(rnd_i), .sat_i(1'b0),
    .y_o(d_res), .lost_o(d_lost));

  always_comb begin
    y_o   = d_res;
    sat_o = 1'b0;
    unique case (pshift_mode_e'(mode_i))
      MODE_H16: begin y_o = h_res; sat_o = sat_i && (|h_lost); end
      MODE_W32: begin y_o = w_res; sat_o = sat_i && (|w_lost); end
      MODE_S32: begin
        y_o   = {{(DW-WW){1'b0}}, w_res[WW-1:0]};
        sat_o = sat_i && w_lost[0];
      end
      MODE_D64: begin y_o = d_res; sat_o = 1'b0 & d_lost; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pshift_top.sv
module pshift_top
  import pshift_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int AW      = AMT_W,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [1:0]    mode_i,
  input  logic          round_en_i,
  input  logic          sat_en_i,
  input  logic          sat_clr_i,
  input  logic [DW-1:0] opa_i,
  input  logic [AW-1:0] shamt_i,
  output logic [DW-1:0] result_o,
  output logic          valid_o,
  output logic          sat_pulse_o,
  output logic          sat_sticky_o
);
  logic [DW-1:0] res_c;
  logic          sat_c;
  logic          pulse_c;

  pshift_core #(.DW(DW), .HW(16), .WW(32), .AW(AW)) u_core (
    .mode_i(mode_i), .rnd_i(round_en_i), .sat_i(sat_en_i),
    .x_i(opa_i), .amt_i(shamt_i), .y_o(res_c), .sat_o(sat_c));

  assign pulse_c = valid_i && sat_c;

  always_ff @(posedge clk) begin
    if (rst)            sat_sticky_o <= 1'b0;
    else if (pulse_c)   sat_sticky_o <= 1'b1;
    else if (sat_clr_i) sat_sticky_o <= 1'b0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result_o    <= '0;
        valid_o     <= 1'b0;
        sat_pulse_o <= 1'b0;
      end else begin
        valid_o     <= valid_i;
        sat_pulse_o <= pulse_c;
        if (valid_i) result_o <= res_c;
      end
    end

    p_pulse_gate_r9: assert property (@(posedge clk) disable iff (rst)
      sat_pulse_o |-> $past(valid_i && sat_en_i));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(result_o));
    p_no_sat64_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mode_i == MODE_D64) |=> !sat_pulse_o);
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mode_i == MODE_S32) |=> (result_o[DW-1:32] == '0));
    p_pulse_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      sat_pulse_o |-> sat_sticky_o);
  end else begin : g_comb
    assign result_o    = res_c;
    assign valid_o     = valid_i;
    assign sat_pulse_o = pulse_c;
  end

  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky_o && !sat_clr_i) |=> sat_sticky_o);
endmodule

// File: tb/pshift_top_bench.sv
module pshift_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i, round_en_i, sat_en_i, sat_clr_i;
  logic [1:0]  mode_i;
  logic [63:0] opa_i;
  logic [7:0]  shamt_i;
  logic [63:0] result_o;
  logic        valid_o, sat_pulse_o, sat_sticky_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pshift_top u_pshift_top (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .round_en_i(round_en_i), .sat_en_i(sat_en_i), .sat_clr_i(sat_clr_i),
    .opa_i(opa_i), .shamt_i(shamt_i), .result_o(result_o), .valid_o(valid_o),
    .sat_pulse_o(sat_pulse_o), .sat_sticky_o(sat_sticky_o));

  // {mode, rnd, sat, opa, shamt, expected result, expected pulse}
  localparam int NV = 16;
  localparam logic [140:0] VEC [NV] = '{
    {2'd0,1'b0,1'b1,64'h0001_0FFF_1000_0000,8'h04,64'h0010_FFF0_FFFF_0000,1'b1},
    {2'd0,1'b0,1'b0,64'h0001_0FFF_1000_0000,8'h04,64'h0010_FFF0_0000_0000,1'b0},
    {2'd0,1'b0,1'b0,64'h8000_00FF_0018_FFFF,8'hFC,64'h0800_000F_0001_0FFF,1'b0},
    {2'd0,1'b1,1'b0,64'h8000_00FF_0018_FFFF,8'hFC,64'h0800_0010_0002_1000,1'b0},
    {2'd1,1'b0,1'b1,64'h0000_0000_0000_0001,8'h28,64'h0000_0000_FFFF_FFFF,1'b1},
    {2'd1,1'b1,1'b0,64'h8000_0000_7FFF_FFFF,8'hE0,64'h0000_0001_0000_0000,1'b0},
    {2'd1,1'b1,1'b0,64'h8000_0000_7FFF_FFFF,8'hDF,64'h0000_0000_0000_0000,1'b0},
    {2'd1,1'b0,1'b0,64'h8000_0000_7FFF_FFFF,8'hE0,64'h0000_0000_0000_0000,1'b0},
    {2'd2,1'b0,1'b1,64'hFFFF_FFFF_4000_0000,8'h01,64'h0000_0000_8000_0000,1'b0},
    {2'd2,1'b0,1'b1,64'hFFFF_FFFF_4000_0000,8'h02,64'h0000_0000_FFFF_FFFF,1'b1},
    {2'd3,1'b0,1'b1,64'hF000_0000_0000_0001,8'h04,64'h0000_0000_0000_0010,1'b0},
    {2'd3,1'b0,1'b1,64'hFFFF_FFFF_FFFF_FFFF,8'h40,64'h0000_0000_0000_0000,1'b0},
    {2'd3,1'b1,1'b0,64'h8000_0000_0000_0000,8'hC0,64'h0000_0000_0000_0001,1'b0},
    {2'd3,1'b1,1'b0,64'h0000_0000_0000_0003,8'hFF,64'h0000_0000_0000_0002,1'b0},
    {2'd0,1'b0,1'b1,64'h0000_0001_0000_0000,8'h7F,64'h0000_FFFF_0000_0000,1'b1},
    {2'd0,1'b1,1'b0,64'hFFFF_FFFF_FFFF_FFFF,8'h80,64'h0000_0000_0000_0000,1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R2/R3";
      1:  return "R4";
      2, 7: return "R5";
      3, 5, 6, 12, 13: return "R6";
      4:  return "R3";
      8, 9: return "R10";
      10, 11: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic v, logic [1:0] m, logic r, logic s, logic c,
                       logic [63:0] a, logic [7:0] sh);
    @(negedge clk);
    valid_i = v; mode_i = m; round_en_i = r; sat_en_i = s;
    sat_clr_i = c; opa_i = a; shamt_i = sh;
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; mode_i = 2'd0; round_en_i = 1'b0;
    sat_en_i = 1'b0; sat_clr_i = 1'b0; opa_i = '0; shamt_i = '0;
    repeat (3) @(negedge clk);
    check("R11 reset result", result_o, 64'h0);
    check("R11 reset valid", {63'h0, valid_o}, 64'h0);
    check("R11 reset sticky", {63'h0, sat_sticky_o}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][140:139], VEC[i][138], VEC[i][137], 1'b0,
            VEC[i][136:73], VEC[i][72:65]);
      check({vec_tag(i), " result"}, result_o, VEC[i][64:1]);
      check({vec_tag(i), " pulse"}, {63'h0, sat_pulse_o}, {63'h0, VEC[i][0]});
      check("R11 valid_o", {63'h0, valid_o}, 64'h1);
    end

    @(negedge clk);
    check("R11 valid drops", {63'h0, valid_o}, 64'h0);
    check("R8 sticky held", {63'h0, sat_sticky_o}, 64'h1);

    issue(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 64'h0, 8'h0);
    check("R8 sticky cleared", {63'h0, sat_sticky_o}, 64'h0);

    issue(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h08);
    check("R9 idle holds result", result_o, 64'h0);
    check("R9 idle no pulse", {63'h0, sat_pulse_o}, 64'h0);
    check("R9 idle no sticky", {63'h0, sat_sticky_o}, 64'h0);

    issue(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h08);
    check("R9 sat off no pulse", {63'h0, sat_pulse_o}, 64'h0);
    check("R4 sat off result", result_o, 64'hFF00_FF00_FF00_FF00);
    check("R9 sat off no sticky", {63'h0, sat_sticky_o}, 64'h0);

    issue(1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 64'h0000_0001_0000_0000, 8'h20);
    check("R8 set beats clear", {63'h0, sat_sticky_o}, 64'h1);
    check("R3 upper lane sat", result_o, 64'hFFFF_FFFF_0000_0000);

    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R11 reset again result", result_o, 64'h0);
    check("R11 reset again sticky", {63'h0, sat_sticky_o}, 64'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule